// File: doc/BRIEF.md
# SMBus Host Command Controller

This block is the transaction engine of an SMBus host. Software fills a small byte-wide register file with a slave address, a command code and up to two data bytes. It then writes a control byte that selects one of four fixed transaction shapes and sets a start bit. The engine walks the chosen shape one byte-level step at a time over a link to a bit-level bus engine. The steps are start condition, byte write, byte read and stop condition. Received bytes land in the data registers.

Each outcome is recorded in a sticky status byte. The outcomes are clean completion, a missing acknowledge from the slave, a lost bus (collision), and a start request with an unusable type. Software clears these flags by writing ones to them. The link toward the bit engine is a valid/ready command channel. Each accepted command is answered by exactly one response pulse, which carries the acknowledge, collision and read-data results.

Top module: `smb_host_ctl`

## Requirements
- R1: Registers sit at offsets status 0, control 2, command 3, address 4, data-low 5, data-high 6. Unused offsets and unused bits read 0, and every register reads 0 after reset.
- R2: A control write with bit 6 set, a type field in bits [4:2] of 0..3, no busy flag and no error flag sets busy (status bit 0) on the next clock. Control reads back only its type field, and no link command is offered while busy is clear.
- R3: Type 0 (quick) issues: start, write of the address register as stored, stop.
- R4: Type 1 (byte) with address bit 0 = 0 issues start, address, command register, stop. With address bit 0 = 1 it issues start, address, one read answered with no-acknowledge into data-low, stop.
- R5: Type 2 (byte data) write issues start, address, command, data-low, stop. The read issues start, address with bit 0 forced 0, command, start, address with bit 0 forced 1, one read with no-acknowledge into data-low, stop.
- R6: Type 3 (word) write sends data-low then data-high after the command. The read, after the repeated start and read address, reads data-low with acknowledge, then data-high with no-acknowledge, then issues stop.
- R7: A no-acknowledge on any written byte sends no further bytes. It issues a stop, then sets device-error (bit 2) and clears busy with interrupt left clear.
- R8: A collision reported on any response ends the transaction at once without a stop, sets collision (bit 3) and clears busy.
- R9: Interrupt (bit 1) is set only on a transaction that completes without error, in the same cycle busy clears.
- R10: A start request is ignored while busy or while any of bits 2..4 is set. Writes to control, command, address and data registers are ignored while busy.
- R11: A start request with a type field of 4..7 and nothing pending issues no link command and sets failed (bit 4).
- R12: Writing 1 to status bits 1..4 clears them. Zeros leave flags unchanged, and bit 0 is not writable.
- R13: A command offered on the link holds its op, byte and acknowledge choice stable until ready is seen. The op codes are 0 start, 1 write, 2 read and 3 stop. Exactly one response is consumed per command, and it must arrive after the acceptance cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register offset for read and write |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data for reg_addr (combinational) |
| lk_valid | output | 1 | Link command offered |
| lk_ready | input | 1 | Link command accepted |
| lk_op | output | 2 | Link op: 0 start, 1 write, 2 read, 3 stop |
| lk_wdata | output | 8 | Byte to send for write ops |
| lk_nack_last | output | 1 | For reads: answer the byte with no-acknowledge |
| lk_rsp_valid | input | 1 | One-cycle response to the last accepted command |
| lk_rsp_nack | input | 1 | Slave did not acknowledge the written byte |
| lk_rsp_coll | input | 1 | Bus collision during the command |
| lk_rsp_data | input | 8 | Byte received for read ops |

## Verification
The hardest cases to reach from the ports are those where the transaction dies partway. These include a no-acknowledge on the command or data byte, and a collision on the final stop. Others are a start request or a register write that arrives while the engine is stalled mid-flight. The bench's link responder takes per-run knobs. These knobs choose which command index answers with a no-acknowledge or a collision, and how many cycles ready is withheld. A sweep can therefore place the fault at every byte position of every shape and check the truncated command log, status byte and data registers against a sequence built in the bench.

// File: rtl/smb_host_pkg.sv
package smb_host_pkg;
  localparam int BYTE_W = 8;
  localparam int ADDR_W = 3;
  localparam int IDX_W  = 3;
  localparam int STS_W  = 5;

  localparam logic [ADDR_W-1:0] OFS_STS = 3'd0;
  localparam logic [ADDR_W-1:0] OFS_CTL = 3'd2;
  localparam logic [ADDR_W-1:0] OFS_CMD = 3'd3;
  localparam logic [ADDR_W-1:0] OFS_ADR = 3'd4;
  localparam logic [ADDR_W-1:0] OFS_DLO = 3'd5;
  localparam logic [ADDR_W-1:0] OFS_DHI = 3'd6;

  localparam int B_BUSY = 0;
  localparam int B_INTR = 1;
  localparam int B_DERR = 2;
  localparam int B_COLL = 3;
  localparam int B_FAIL = 4;
  localparam int B_GO   = 6;

  typedef enum logic [1:0] {LK_START = 2'd0, LK_WRITE = 2'd1, LK_READ = 2'd2, LK_STOP = 2'd3} lk_op_e;

  typedef enum logic [3:0] {
    SP_START, SP_ADDR, SP_ADDR_W, SP_ADDR_R, SP_CMD, SP_DLO, SP_DHI,
    SP_RLO_ACK, SP_RLO_NACK, SP_RHI_NACK, SP_STOP
  } step_e;

  // Step idx of the shape selected by kind and direction; past the end is stop.
  function automatic step_e step_at(input logic [2:0] kind, input logic rd, input logic [IDX_W-1:0] idx);
    step_e s;
    s = SP_STOP;
    if (idx == 3'd0) s = SP_START;
    else if ((kind == 3'd2 || kind == 3'd3) && rd) begin
      case (idx)
        3'd1: s = SP_ADDR_W;
        3'd2: s = SP_CMD;
        3'd3: s = SP_START;
        3'd4: s = SP_ADDR_R;
        3'd5: s = (kind == 3'd3) ? SP_RLO_ACK : SP_RLO_NACK;
        3'd6: s = (kind == 3'd3) ? SP_RHI_NACK : SP_STOP;
        default: s = SP_STOP;
      endcase
    end else begin
      case (idx)
        3'd1: s = SP_ADDR;
        3'd2: s = (kind == 3'd0) ? SP_STOP : (kind == 3'd1 && rd) ? SP_RLO_NACK : SP_CMD;
        3'd3: s = (kind >= 3'd2) ? SP_DLO : SP_STOP;
        3'd4: s = (kind == 3'd3) ? SP_DHI : SP_STOP;
        default: s = SP_STOP;
      endcase
    end
    return s;
  endfunction
endpackage

// File: rtl/smb_host_regs.sv
module smb_host_regs
  import smb_host_pkg::*;
(
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  wr_en,
  input  logic [ADDR_W-1:0]     addr,
  input  logic [BYTE_W-1:0]     wdata,
  output logic [BYTE_W-1:0]     rdata,
  input  logic                  fin_ok,
  input  logic                  fin_nack,
  input  logic                  fin_coll,
  input  logic                  cap_lo_we,
  input  logic                  cap_hi_we,
  input  logic [BYTE_W-1:0]     cap_data,
  output logic                  go,
  output logic [2:0]            kind,
  output logic [BYTE_W-1:0]     adr_q,
  output logic [BYTE_W-1:0]     cmd_q,
  output logic [BYTE_W-1:0]     dlo_q,
  output logic [BYTE_W-1:0]     dhi_q,
  output logic [STS_W-1:0]      sts
);
  logic [STS_W-1:0] sts_q;
  logic [2:0]       kind_q;
  logic             wr_ok, start_req, can_start, bad;
  logic [STS_W-1:0] clr;

  assign wr_ok     = wr_en && !sts_q[B_BUSY];
  assign start_req = wr_en && addr == OFS_CTL && wdata[B_GO];
  assign can_start = !sts_q[B_BUSY] && !(|sts_q[B_FAIL:B_DERR]);
  assign go        = start_req && can_start && (wdata[4:2] <= 3'd3);
  assign bad       = start_req && can_start && (wdata[4:2] > 3'd3);
  assign clr       = (wr_en && addr == OFS_STS) ? {wdata[STS_W-1:1], 1'b0} : '0;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sts_q <= '0;
    end else begin
      if (go) sts_q[B_BUSY] <= 1'b1;
      else if (fin_ok || fin_nack || fin_coll) sts_q[B_BUSY] <= 1'b0;
      sts_q[B_INTR] <= fin_ok   | (sts_q[B_INTR] & ~clr[B_INTR]);
      sts_q[B_DERR] <= fin_nack | (sts_q[B_DERR] & ~clr[B_DERR]);
      sts_q[B_COLL] <= fin_coll | (sts_q[B_COLL] & ~clr[B_COLL]);
      sts_q[B_FAIL] <= bad      | (sts_q[B_FAIL] & ~clr[B_FAIL]);
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      kind_q <= '0;
      adr_q  <= '0;
      cmd_q  <= '0;
      dlo_q  <= '0;
      dhi_q  <= '0;
    end else begin
      if (wr_ok && addr == OFS_CTL) kind_q <= wdata[4:2];
      if (wr_ok && addr == OFS_CMD) cmd_q  <= wdata;
      if (wr_ok && addr == OFS_ADR) adr_q  <= wdata;
      if (cap_lo_we) dlo_q <= cap_data;
      else if (wr_ok && addr == OFS_DLO) dlo_q <= wdata;
      if (cap_hi_we) dhi_q <= cap_data;
      else if (wr_ok && addr == OFS_DHI) dhi_q <= wdata;
    end
  end

  always_comb begin
    case (addr)
      OFS_STS: rdata = {{(BYTE_W-STS_W){1'b0}}, sts_q};
      OFS_CTL: rdata = {3'b000, kind_q, 2'b00};
      OFS_CMD: rdata = cmd_q;
      OFS_ADR: rdata = adr_q;
      OFS_DLO: rdata = dlo_q;
      OFS_DHI: rdata = dhi_q;
      default: rdata = '0;
    endcase
  end

  assign kind = kind_q;
  assign sts  = sts_q;
endmodule

// File: rtl/smb_host_seq.sv
module smb_host_seq
  import smb_host_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              go,
  input  logic [2:0]        kind,
  input  logic [BYTE_W-1:0] adr,
  input  logic [BYTE_W-1:0] cmd,
  input  logic [BYTE_W-1:0] dlo,
  input  logic [BYTE_W-1:0] dhi,
  output logic              lk_valid,
  input  logic              lk_ready,
  output logic [1:0]        lk_op,
  output logic [BYTE_W-1:0] lk_wdata,
  output logic              lk_nack_last,
  input  logic              lk_rsp_valid,
  input  logic              lk_rsp_nack,
  input  logic              lk_rsp_coll,
  input  logic [BYTE_W-1:0] lk_rsp_data,
  output logic              fin_ok,
  output logic              fin_nack,
  output logic              fin_coll,
  output logic              cap_lo_we,
  output logic              cap_hi_we,
  output logic [BYTE_W-1:0] cap_data
);
  typedef enum logic [1:0] {S_IDLE, S_ISSUE, S_WAIT} st_e;
  st_e              st_q;
  logic [IDX_W-1:0] idx_q;
  logic             abort_q;
  step_e            cur;
  lk_op_e           op;
  logic             take, is_stop;

  assign cur = abort_q ? SP_STOP : step_at(kind, adr[0], idx_q);

  always_comb begin
    op           = LK_WRITE;
    lk_wdata     = '0;
    lk_nack_last = 1'b0;
    case (cur)
      SP_START:    op = LK_START;
      SP_STOP:     op = LK_STOP;
      SP_ADDR:     lk_wdata = adr;
      SP_ADDR_W:   lk_wdata = {adr[BYTE_W-1:1], 1'b0};
      SP_ADDR_R:   lk_wdata = {adr[BYTE_W-1:1], 1'b1};
      SP_CMD:      lk_wdata = cmd;
      SP_DLO:      lk_wdata = dlo;
      SP_DHI:      lk_wdata = dhi;
      SP_RLO_ACK:  op = LK_READ;
      default: begin
        op           = LK_READ;
        lk_nack_last = 1'b1;
      end
    endcase
  end

  assign lk_op     = op;
  assign lk_valid  = (st_q == S_ISSUE);
  assign take      = (st_q == S_WAIT) && lk_rsp_valid;
  assign is_stop   = (cur == SP_STOP);
  assign fin_coll  = take && lk_rsp_coll;
  assign fin_ok    = take && !lk_rsp_coll && is_stop && !abort_q;
  assign fin_nack  = take && !lk_rsp_coll && is_stop && abort_q;
  assign cap_lo_we = take && !lk_rsp_coll && (cur == SP_RLO_ACK || cur == SP_RLO_NACK);
  assign cap_hi_we = take && !lk_rsp_coll && (cur == SP_RHI_NACK);
  assign cap_data  = lk_rsp_data;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q    <= S_IDLE;
      idx_q   <= '0;
      abort_q <= 1'b0;
    end else begin
      case (st_q)
        S_IDLE: if (go) begin
          st_q    <= S_ISSUE;
          idx_q   <= '0;
          abort_q <= 1'b0;
        end
        S_ISSUE: if (lk_ready) st_q <= S_WAIT;
        default: if (lk_rsp_valid) begin
          if (lk_rsp_coll || is_stop) begin
            st_q <= S_IDLE;
          end else begin
            if (op == LK_WRITE && lk_rsp_nack) abort_q <= 1'b1;
            idx_q <= idx_q + 3'd1;
            st_q  <= S_ISSUE;
          end
        end
      endcase
    end
  end
endmodule

// File: rtl/smb_host_ctl.sv
module smb_host_ctl
  import smb_host_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_we,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [BYTE_W-1:0] reg_wdata,
  output logic [BYTE_W-1:0] reg_rdata,
  output logic              lk_valid,
  input  logic              lk_ready,
  output logic [1:0]        lk_op,
  output logic [BYTE_W-1:0] lk_wdata,
  output logic              lk_nack_last,
  input  logic              lk_rsp_valid,
  input  logic              lk_rsp_nack,
  input  logic              lk_rsp_coll,
  input  logic [BYTE_W-1:0] lk_rsp_data
);
  logic              go, fin_ok, fin_nack, fin_coll, cap_lo_we, cap_hi_we;
  logic [2:0]        kind;
  logic [BYTE_W-1:0] adr_q, cmd_q, dlo_q, dhi_q, cap_data;
  logic [STS_W-1:0]  sts_w;

  smb_host_regs regs_i (
    .clk(clk), .rst_n(rst_n), .wr_en(reg_we), .addr(reg_addr), .wdata(reg_wdata),
    .rdata(reg_rdata), .fin_ok(fin_ok), .fin_nack(fin_nack), .fin_coll(fin_coll),
    .cap_lo_we(cap_lo_we), .cap_hi_we(cap_hi_we), .cap_data(cap_data), .go(go),
    .kind(kind), .adr_q(adr_q), .cmd_q(cmd_q), .dlo_q(dlo_q), .dhi_q(dhi_q), .sts(sts_w)
  );

  smb_host_seq seq_i (
    .clk(clk), .rst_n(rst_n), .go(go), .kind(kind), .adr(adr_q), .cmd(cmd_q),
    .dlo(dlo_q), .dhi(dhi_q), .lk_valid(lk_valid), .lk_ready(lk_ready), .lk_op(lk_op),
    .lk_wdata(lk_wdata), .lk_nack_last(lk_nack_last), .lk_rsp_valid(lk_rsp_valid),
    .lk_rsp_nack(lk_rsp_nack), .lk_rsp_coll(lk_rsp_coll), .lk_rsp_data(lk_rsp_data),
    .fin_ok(fin_ok), .fin_nack(fin_nack), .fin_coll(fin_coll), .cap_lo_we(cap_lo_we),
    .cap_hi_we(cap_hi_we), .cap_data(cap_data)
  );
endmodule

// File: rtl/smb_host_chk.sv
module smb_host_chk (
  input logic       clk,
  input logic       rst_n,
  input logic [4:0] sts,
  input logic       lk_valid,
  input logic       lk_ready,
  input logic [1:0] lk_op,
  input logic [7:0] lk_wdata,
  input logic       lk_nack_last
);
  AST_INTR_AT_FINISH: assert property (@(posedge clk) disable iff (!rst_n)
    (sts[1] && !$past(sts[1])) |-> ($past(sts[0]) && !sts[0])); // R9
  AST_QUIET_WHEN_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !sts[0] |-> !lk_valid); // R2
  AST_CMD_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (lk_valid && !lk_ready) |=> (lk_valid && $stable(lk_op) && $stable(lk_wdata) && $stable(lk_nack_last))); // R13
  AST_NO_START_WITH_ERR: assert property (@(posedge clk) disable iff (!rst_n)
    (!sts[0] && (|sts[4:2])) |=> !sts[0]); // R10
  AST_ONE_OUTCOME: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(sts[3:1] & ~$past(sts[3:1])) <= 1); // R7
endmodule

bind smb_host_ctl smb_host_chk chk_i (
  .clk(clk), .rst_n(rst_n), .sts(sts_w), .lk_valid(lk_valid), .lk_ready(lk_ready),
  .lk_op(lk_op), .lk_wdata(lk_wdata), .lk_nack_last(lk_nack_last)
);

// File: tb/smb_host_ctl_tb_top.sv
module smb_host_ctl_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic reg_we = 1'b0;
  logic [2:0] reg_addr = '0;
  logic [7:0] reg_wdata = '0;
  logic [7:0] reg_rdata;
  logic lk_valid, lk_nack_last;
  logic lk_ready = 1'b0;
  logic [1:0] lk_op;
  logic [7:0] lk_wdata;
  logic lk_rsp_valid = 1'b0, lk_rsp_nack = 1'b0, lk_rsp_coll = 1'b0;
  logic [7:0] lk_rsp_data = '0;

  always #10 clk = ~clk;

  smb_host_ctl dut_i (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .lk_valid(lk_valid), .lk_ready(lk_ready), .lk_op(lk_op),
    .lk_wdata(lk_wdata), .lk_nack_last(lk_nack_last), .lk_rsp_valid(lk_rsp_valid),
    .lk_rsp_nack(lk_rsp_nack), .lk_rsp_coll(lk_rsp_coll), .lk_rsp_data(lk_rsp_data)
  );

  int n_chk = 0, n_err = 0;
  int log_n = 0, nack_at = -1, coll_at = -1, stall = 0, ri;
  logic [7:0] seed = 8'h00;
  logic [1:0] log_op [0:31];
  logic [7:0] log_dat [0:31];
  logic       log_nl [0:31];
  logic [1:0] e_op [0:7];
  logic [7:0] e_dat [0:7];
  logic       e_nl [0:7];
  int e_n, e_rlo, e_rhi;

  task automatic check(input string rq, input string what, input int act, input int exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h", rq, what, act, exp);
    end
  endtask

  function automatic logic [7:0] rdat(input int i);
    return (8'h5A ^ seed) + 8'(i * 29);
  endfunction

  // link responder: ready at a negedge, response one cycle later
  initial begin
    forever begin
      @(negedge clk);
      lk_rsp_valid = 1'b0;
      if (lk_valid) begin
        if (stall > 0) begin
          stall--;
        end else begin
          lk_ready = 1'b1;
          ri = log_n;
          if (log_n < 32) begin
            log_op[log_n] = lk_op; log_dat[log_n] = lk_wdata; log_nl[log_n] = lk_nack_last;
          end
          log_n++;
          @(negedge clk);
          lk_ready = 1'b0;
          lk_rsp_valid = 1'b1;
          lk_rsp_nack = (ri == nack_at);
          lk_rsp_coll = (ri == coll_at);
          lk_rsp_data = rdat(ri);
        end
      end
    end
  end

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk); reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk); reg_we = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [7:0] d);
    reg_addr = a; #1; d = reg_rdata;
  endtask

  task automatic wait_idle();
    logic [7:0] s;
    for (int k = 0; k < 400; k++) begin
      @(negedge clk); rd(3'd0, s);
      if (!s[0]) break;
    end
  endtask

  task automatic push(input logic [1:0] op, input logic [7:0] d, input logic nl);
    e_op[e_n] = op; e_dat[e_n] = d; e_nl[e_n] = nl;
    if (op == 2'd2 && e_rlo < 0) e_rlo = e_n; else if (op == 2'd2) e_rhi = e_n;
    e_n++;
  endtask

  task automatic build(input int kind, input logic [7:0] a, input logic [7:0] c,
                       input logic [7:0] lo, input logic [7:0] hi);
    e_n = 0; e_rlo = -1; e_rhi = -1;
    push(2'd0, 8'h00, 1'b0);
    if (kind >= 2 && a[0]) begin
      push(2'd1, {a[7:1], 1'b0}, 1'b0); push(2'd1, c, 1'b0);
      push(2'd0, 8'h00, 1'b0); push(2'd1, {a[7:1], 1'b1}, 1'b0);
      if (kind == 3) begin push(2'd2, 8'h00, 1'b0); push(2'd2, 8'h00, 1'b1); end
      else push(2'd2, 8'h00, 1'b1);
    end else begin
      push(2'd1, a, 1'b0);
      if (kind == 1 && a[0]) push(2'd2, 8'h00, 1'b1);
      else if (kind >= 1) push(2'd1, c, 1'b0);
      if (kind >= 2) push(2'd1, lo, 1'b0);
      if (kind == 3) push(2'd1, hi, 1'b0);
    end
    push(2'd3, 8'h00, 1'b0);
  endtask

  function automatic string ktag(input int kind);
    case (kind)
      0: return "R3";
      1: return "R4";
      2: return "R5";
      default: return "R6";
    endcase
  endfunction

  logic [7:0] c_lo, c_hi;
  int c_kind, c_nk, c_cl;

  task automatic start_txn(input int kind, input logic [7:0] a, input logic [7:0] c,
                           input logic [7:0] lo, input logic [7:0] hi, input int nk, input int cl);
    build(kind, a, c, lo, hi);
    c_lo = lo; c_hi = hi; c_kind = kind; c_nk = nk; c_cl = cl;
    wr(3'd3, c); wr(3'd4, a); wr(3'd5, lo); wr(3'd6, hi);
    log_n = 0; nack_at = nk; coll_at = cl;
    wr(3'd2, 8'h40 | 8'(kind << 2));
  endtask

  task automatic end_txn();
    string t;
    int trunc;
    logic [7:0] v;
    logic [1:0] xo;
    wait_idle();
    t = (c_cl >= 0) ? "R8" : (c_nk >= 0) ? "R7" : ktag(c_kind);
    trunc = (c_cl >= 0) ? c_cl + 1 : (c_nk >= 0) ? c_nk + 2 : e_n;
    check(t, "command count", log_n, trunc);
    for (int i = 0; i < trunc && i < log_n; i++) begin
      xo = (c_cl < 0 && c_nk >= 0 && i == c_nk + 1) ? 2'd3 : e_op[i];
      check(t, $sformatf("op[%0d]", i), log_op[i], xo);
      if (xo == 2'd1) check(t, $sformatf("byte[%0d]", i), log_dat[i], e_dat[i]);
      if (xo == 2'd2) check(t, $sformatf("nack_last[%0d]", i), log_nl[i], e_nl[i]);
    end
    rd(3'd0, v);
    check((c_cl < 0 && c_nk < 0) ? "R9" : t, "status", v,
          (c_cl >= 0) ? 8'h08 : (c_nk >= 0) ? 8'h04 : 8'h02);
    rd(3'd5, v);
    check(t, "data-low", v, (c_cl < 0 && c_nk < 0 && e_rlo >= 0) ? rdat(e_rlo) : c_lo);
    rd(3'd6, v);
    check(t, "data-high", v, (c_cl < 0 && c_nk < 0 && e_rhi >= 0) ? rdat(e_rhi) : c_hi);
    wr(3'd0, 8'h1E);
    rd(3'd0, v);
    check("R12", "status after clear", v, 8'h00);
    nack_at = -1; coll_at = -1;
  endtask

  task automatic finish_sim();
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_err++;
    $display("FAIL watchdog: actual hung expected done");
    finish_sim();
  end

  initial begin
    logic [7:0] v;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    for (int a = 0; a < 8; a++) begin
      rd(3'(a), v);
      check("R1", $sformatf("reset reg %0d", a), v, 8'h00);
    end
    check("R2", "idle link", lk_valid, 1'b0);

    // R2 control readback, R1 register map
    wr(3'd2, 8'h8F); rd(3'd2, v); check("R2", "ctl readback", v, 8'h0C);
    rd(3'd0, v); check("R2", "no start without go bit", v, 8'h00);
    wr(3'd3, 8'hC3); rd(3'd3, v); check("R1", "cmd reg", v, 8'hC3);
    wr(3'd4, 8'h9A); rd(3'd4, v); check("R1", "addr reg", v, 8'h9A);
    wr(3'd7, 8'hFF); rd(3'd7, v); check("R1", "unused offset", v, 8'h00);

    // R2 busy next cycle
    build(1, 8'h20, 8'h11, 8'h00, 8'h00);
    log_n = 0; stall = 4;
    @(negedge clk); reg_we = 1'b1; reg_addr = 3'd2; reg_wdata = 8'h44;
    @(negedge clk); reg_we = 1'b0; rd(3'd0, v);
    check("R2", "busy after start", v[0], 1'b1);
    c_kind = 1; c_nk = -1; c_cl = -1; c_lo = 8'h00; c_hi = 8'h00;
    wr(3'd3, 8'h11); wr(3'd4, 8'h20); // ignored while busy (cmd/addr already 0xC3/0x9A)
    build(1, 8'h9A, 8'hC3, 8'h00, 8'h00);
    end_txn();
    rd(3'd3, v); check("R10", "cmd write ignored while busy", v, 8'hC3);

    // sweep all shapes, both directions, several addresses and seeds
    for (int k = 0; k < 4; k++)
      for (int r = 0; r < 2; r++)
        for (int s = 0; s < 3; s++) begin
          seed = 8'(s * 71 + k * 13 + r);
          start_txn(k, 8'(((s * 37 + 5) << 1) | r), 8'(8'h30 + s), 8'(8'h81 + k), 8'(8'hC4 ^ s), -1, -1);
          end_txn();
        end

    // R7 no-acknowledge at address for every shape; at last written byte
    for (int k = 0; k < 4; k++)
      for (int r = 0; r < 2; r++) begin
        start_txn(k, 8'h6C | 8'(r), 8'h21, 8'h32, 8'h43, 1, -1);
        end_txn();
        if (k >= 1 && r == 0) begin
          start_txn(k, 8'h6C, 8'h21, 8'h32, 8'h43, e_n - 2, -1);
          end_txn();
        end
      end
    start_txn(3, 8'h6D, 8'h55, 8'h01, 8'h02, 2, -1); end_txn(); // R7 on command before restart

    // R8 collision at first, middle and stop positions
    start_txn(2, 8'h41, 8'h10, 8'h20, 8'h30, -1, 0); end_txn();
    start_txn(3, 8'h41, 8'h10, 8'h20, 8'h30, -1, 3); end_txn();
    start_txn(3, 8'h40, 8'h10, 8'h20, 8'h30, -1, 5); end_txn();

    // R10 start and writes ignored while busy, under back-pressure (R13)
    stall = 25;
    start_txn(2, 8'h50, 8'h77, 8'h66, 8'h99, -1, -1);
    wr(3'd5, 8'hEE);
    wr(3'd2, 8'h4C);
    end_txn();
    check("R13", "back-pressured command count", log_n, 5);

    // R11 invalid type; R10 start refused while failed pending
    log_n = 0;
    wr(3'd2, 8'h54);
    rd(3'd0, v); check("R11", "failed flag", v, 8'h10);
    wr(3'd2, 8'h40);
    repeat (6) @(negedge clk);
    rd(3'd0, v); check("R10", "start refused with error", v, 8'h10);
    check("R11", "no link traffic", log_n, 0);
    // R12 bit 0 not writable, partial clears
    wr(3'd0, 8'h03); rd(3'd0, v); check("R12", "zeros keep flag", v, 8'h10);
    wr(3'd0, 8'h11); rd(3'd0, v); check("R12", "w1c failed", v, 8'h00);

    // R9 interrupt sticky, start allowed with only interrupt pending
    start_txn(0, 8'hA0, 8'h00, 8'h00, 8'h00, -1, -1);
    wait_idle();
    start_txn(0, 8'hA2, 8'h00, 8'h00, 8'h00, -1, -1);
    wait_idle();
    check("R9", "start with interrupt pending", log_n, 3);
    rd(3'd0, v); check("R9", "interrupt held", v, 8'h02);
    wr(3'd0, 8'h02); rd(3'd0, v); check("R12", "w1c interrupt", v, 8'h00);

    finish_sim();
  end
endmodule